// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers fourteen single-cycle event pulses from a serial port (FIFO levels, line errors, the clear-to-send change, timeout, break completion and a bus fault) into a sticky status register. Each status bit is ANDed with a matching enable bit, and the OR of the results drives one active-high, level-sensitive interrupt line.

A service routine reads the status register and writes the same value back. This clears only the bits it saw, so any event that arrives later is kept. The routine then handles the receive, transmit or modem work that the bits point to. Three masked group flags give the same grouping directly, so the handler can decide where to go without decoding the bits itself. Register access is one select line and a write strobe. The selected register always appears on the read bus.

Top module: `isr_unit`

## Requirements
- R1: Event input `evt_i[k]` sets status bit k. The fixed meanings are: 0 transmit holding empty, 1 receive holding full, 2 transmit FIFO almost empty, 3 transmit FIFO empty, 4 receive FIFO almost full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity error, 9 framing error, 10 clear-to-send toggled, 11 receive timeout, 12 break finished, 13 bus error.
- R2: A one-cycle pulse on `evt_i[k]` makes status bit k read as 1 from the clock edge that samples the pulse.
- R3: A status bit that is set stays set until a clearing write removes it, whatever the event input does afterwards.
- R4: A write with `reg_sel_i`=0 (status) clears each status bit whose `wr_data_i` bit is 1 and leaves bits written 0 unchanged. Writing back a value just read therefore clears exactly those bits.
- R5: If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: `irq_o` is high in exactly those cycles where some bit is set in both the status register and the enable register. It follows the registers with no added delay.
- R7: A write with `reg_sel_i`=1 loads the enable register, which uses the same bit layout as status. Reading with `reg_sel_i`=1 returns it. Writing zero masks every source.
- R8: Bits 31:14 of both registers read as zero and writes to them have no effect.
- R9: `rx_pend_o` is the OR of masked bits 4, 5, 7, 8, 9 and 11. `tx_pend_o` is the OR of masked bits 2, 3 and 6. `mdm_pend_o` is masked bit 10.
- R10: After reset both registers are zero and all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 14 | Event pulses, one per source |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Contents of the selected register |
| irq_o | output | 1 | Level interrupt, active high |
| rx_pend_o | output | 1 | A receive-group source is pending and enabled |
| tx_pend_o | output | 1 | A transmit-group source is pending and enabled |
| mdm_pend_o | output | 1 | The clear-to-send toggle is pending and enabled |

## Verification
Any wrong status or enable state can be seen at the read port one cycle after the stimulus that caused it. The interrupt and group outputs expose a bad mask or grouping in the same cycle. The sweep pulses every source alone, both masked and unmasked, and checks the position it lands in, the group flag it raises and that a write-back clears it. Collisions between an event and a clear, partial clears and a long run of pseudo-random mixed traffic would expose a lost event or a clear that spills over onto a neighbouring bit within one cycle.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int NUM_SRC = 14;

    localparam logic [NUM_SRC-1:0] RX_GRP_MASK  = 14'h0BB0; // bits 4,5,7,8,9,11
    localparam logic [NUM_SRC-1:0] TX_GRP_MASK  = 14'h004C; // bits 2,3,6
    localparam logic [NUM_SRC-1:0] MDM_GRP_MASK = 14'h0400; // bit 10

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } src_vec_t;
endpackage

// File: rtl/isr_evt_latch.sv
module isr_evt_latch
    import isr_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] stat_o
);
    typedef struct packed {
        logic [N-1:0] stat;
    } latch_st_t;

    latch_st_t    st_d, st_q;
    logic [N-1:0] bit_nxt;

    // each bit: an event wins over a clear in the same cycle
    for (genvar k = 0; k < N; k++) begin : g_bit
        assign bit_nxt[k] = evt_i[k] | (st_q.stat[k] & ~(clr_en_i & clr_mask_i[k]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = bit_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/isr_en_reg.sv
module isr_en_reg
    import isr_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ld_i,
    input  logic [N-1:0] ld_val_i,
    output logic [N-1:0] en_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) st_d.en = ld_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen
    import isr_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o,
    output logic         rx_pend_o,
    output logic         tx_pend_o,
    output logic         mdm_pend_o
);
    logic [N-1:0] masked;

    always_comb begin
        masked     = stat_i & en_i;
        irq_o      = |masked;
        rx_pend_o  = |(masked & RX_GRP_MASK[N-1:0]);
        tx_pend_o  = |(masked & TX_GRP_MASK[N-1:0]);
        mdm_pend_o = |(masked & MDM_GRP_MASK[N-1:0]);
    end
endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_sel_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               rx_pend_o,
    output logic               tx_pend_o,
    output logic               mdm_pend_o
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] stat_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] wr_low;
    logic               stat_wr;
    logic               en_wr;
    logic               unused_hi;

    assign wr_low    = wr_data_i[NUM_SRC-1:0];
    assign unused_hi = ^wr_data_i[DATA_W-1:NUM_SRC];
    assign stat_wr   = wr_en_i & (reg_sel_e'(reg_sel_i) == SEL_STATUS);
    assign en_wr     = wr_en_i & (reg_sel_e'(reg_sel_i) == SEL_ENABLE);

    isr_evt_latch #(.N(NUM_SRC)) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_i),
        .clr_en_i   (stat_wr),
        .clr_mask_i (wr_low),
        .stat_o     (stat_w)
    );

    isr_en_reg #(.N(NUM_SRC)) u_en (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (en_wr),
        .ld_val_i (wr_low),
        .en_o     (en_w)
    );

    isr_irq_gen #(.N(NUM_SRC)) u_irq (
        .stat_i     (stat_w),
        .en_i       (en_w),
        .irq_o      (irq_o),
        .rx_pend_o  (rx_pend_o),
        .tx_pend_o  (tx_pend_o),
        .mdm_pend_o (mdm_pend_o)
    );

    always_comb begin
        if (reg_sel_e'(reg_sel_i) == SEL_ENABLE) rd_data_o = {{PAD_W{1'b0}}, en_w};
        else                                     rd_data_o = {{PAD_W{1'b0}}, stat_w};
    end
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk
    import isr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               reg_sel_i,
    input logic               wr_en_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] stat_w,
    input logic [NUM_SRC-1:0] en_w
);
    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((stat_w & $past(evt_i)) == $past(evt_i))); // R2

    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && reg_sel_i == SEL_STATUS) |=> ((stat_w & $past(stat_w)) == $past(stat_w))); // R3

    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && reg_sel_i == SEL_STATUS)
        |=> ((stat_w & $past(wr_data_i[NUM_SRC-1:0] & ~evt_i)) == '0)); // R4

    AST_NO_EN_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_w == '0) |-> !irq_o); // R7

    AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && reg_sel_i == SEL_ENABLE) |=> (en_w == $past(wr_data_i[NUM_SRC-1:0]))); // R7

    AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DATA_W-1:NUM_SRC] == '0); // R8
endmodule

bind isr_unit isr_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .reg_sel_i (reg_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .stat_w    (stat_w),
    .en_w      (en_w)
);

// File: tb/isr_unit_test.sv
module isr_unit_test;
    localparam int N = 14;
    localparam logic [N-1:0] RXM = 14'h0BB0;
    localparam logic [N-1:0] TXM = 14'h004C;
    localparam logic [N-1:0] MDM = 14'h0400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [31:0]   wdat = '0;
    logic [31:0]   rdat;
    logic          irq, rxp, txp, mdp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_en = '0;

    always #2 clk = ~clk;

    isr_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_sel_i(sel),
        .wr_en_i(wr), .wr_data_i(wdat), .rd_data_o(rdat), .irq_o(irq),
        .rx_pend_o(rxp), .tx_pend_o(txp), .mdm_pend_o(mdp)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock of stimulus, model updated from the requirements
    task automatic cyc(input logic [N-1:0] e, input logic w, input logic s, input logic [31:0] d);
        @(negedge clk);
        evt = e; wr = w; sel = s; wdat = d;
        @(posedge clk);
        if (w && !s) m_stat = (m_stat & ~d[N-1:0]) | e;
        else         m_stat = m_stat | e;
        if (w && s)  m_en = d[N-1:0];
        #1;
        evt = '0; wr = 1'b0; wdat = '0;
    endtask

    task automatic check_all(input string req);
        logic [N-1:0] mk;
        @(negedge clk);
        mk = m_stat & m_en;
        sel = 1'b0; #1;
        cmp({req, " status"}, rdat, {18'b0, m_stat});
        sel = 1'b1; #1;
        cmp({req, " enable"}, rdat, {18'b0, m_en});
        cmp({req, " irq R6"}, {31'b0, irq}, {31'b0, |mk});
        cmp({req, " groups R9"}, {29'b0, rxp, txp, mdp},
            {29'b0, |(mk & RXM), |(mk & TXM), |(mk & MDM)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lf;
        repeat (3) @(posedge clk);
        check_all("R10 reset");
        @(negedge clk); rst_n = 1'b1;
        check_all("R10 after release");

        // R1 R2 R3 R4 R9: every source alone, masked and unmasked
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 2; m++) begin
                cyc('0, 1'b1, 1'b1, m ? (32'h1 << i) : 32'h0);
                cyc(N'(1) << i, 1'b0, 1'b0, 32'h0);
                check_all("R1 R2 single source");
                cyc('0, 1'b0, 1'b0, 32'h0);
                cyc('0, 1'b0, 1'b0, 32'h0);
                check_all("R3 held");
                cyc('0, 1'b1, 1'b0, ~(32'h1 << i));
                check_all("R4 other bits cleared only");
                cyc('0, 1'b1, 1'b0, {18'b0, m_stat});
                check_all("R4 write-back clears");
            end
        end

        // R5 collision: event and clear of same bit
        cyc(14'h0A5A, 1'b0, 1'b0, 32'h0);
        cyc(14'h0002, 1'b1, 1'b0, 32'h0000_3FFF);
        check_all("R5 event beats clear");
        sel = 1'b0; #1;
        cmp("R5 collided bit", rdat, 32'h2);

        // R7 zero enable masks all; R8 upper bits
        cyc(14'h3FFF, 1'b1, 1'b1, 32'hFFFF_FFFF);
        check_all("R8 upper enable ignored");
        cyc('0, 1'b1, 1'b1, 32'hFFFF_C000);
        check_all("R7 R8 zero enable masks");
        @(negedge clk);
        cmp("R7 irq masked", {31'b0, irq}, 32'h0);
        cyc('0, 1'b1, 1'b0, 32'hFFFF_C000);
        check_all("R8 upper clear ignored");

        // mixed pseudo-random traffic
        lf = 14'h1ACE;
        for (int t = 0; t < 3000; t++) begin
            lf = {lf[12:0], lf[13] ^ lf[12] ^ lf[11] ^ lf[1]};
            case (t % 4)
                0: cyc(lf & 14'h1111, 1'b0, 1'b0, 32'h0);
                1: cyc(lf & 14'h0842, 1'b1, 1'b0, {18'b0, ~lf});
                2: cyc(lf & 14'h2024, 1'b1, 1'b1, {18'hABC, lf});
                default: cyc(lf, 1'b1, 1'b0, {18'b0, m_stat});
            endcase
            check_all("R2 R4 R5 R6 mixed");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule